// File: doc/BRIEF.md
# Two-Channel Capture/Compare Timer

A peripheral timer with one 16-bit up-counter and two channels. The counter either runs freely through its full range or returns to zero after a programmable modulo value. It advances on a count enable. That enable comes either from a power-of-two divider of the bus clock or from rising edges on an external clock pin, which are first synchronised.

Each channel works on its own as an input capture or as an output compare. A capture stores the counter value when a selected edge arrives on the channel input. A compare sets, clears or toggles the channel pin when the counter reaches the channel value. A channel pin can also toggle on every counter wrap. Channel 0 can take channel 1's value register as a partner and produce a PWM wave whose duty value changes only at a wrap, so no pulse is ever cut short.

Software reaches everything through a small register port. Reads return data one cycle after `rd_en`. Status flags are cleared by a read that sees the flag set, followed by a write of zero to it.

Top module: `cc_timer`

## Requirements
- R1: The counter is 16 bits and only counts up, by one per count enable. With MOD (address 1) nonzero it goes from MOD to 0. With MOD = 0 it goes from 0xFFFF to 0.
- R2: Reading CNT (address 2) returns the current count and does not change the counting sequence.
- R3: CTRL (address 0) bits 4:2 select the count enable. A code k from 0 to 6 gives one enable every 2^k bus clocks. Code 7 counts rising edges of `ext_clk` after a two-stage synchroniser.
- R4: CTRL bit 0 (stop) halts both the counter and the divider. After reset CTRL reads 0x0001 and CNT, MOD, the pins and the interrupts are 0.
- R5: Writing 1 to CTRL bit 1 clears the counter and the divider. This bit is not stored and reads 0.
- R6: The overflow flag (CTRL bit 7) is set when the counter goes to 0 by a wrap. It is cleared only by a CTRL write with bit 7 = 0 that follows a CTRL read which saw it set, with no CTRL write between them. `irq_ovf` is the flag ANDed with CTRL bit 5.
- R7: Channel n has its control register at address 3+2n and its value register at 4+2n. Mode bits 1:0 = 01 select capture. Bit 2 enables rising edges and bit 3 enables falling edges. The synchronised edge copies CNT into the value register. An edge that is not enabled changes nothing.
- R8: Mode 10 selects compare. When the counter steps to the channel value, the pin changes on that same clock edge according to bits 3:2: 01 toggles, 10 clears, 11 sets.
- R9: In compare mode with bit 4 set, the pin toggles on every counter wrap unless a match happens on the same edge.
- R10: With channel 0 in compare mode and its bit 6 set, writes to either value register go to channel 0's value register. The duty used is loaded from it at each wrap. The pin goes high on a wrap and low on a match with the duty.
- R11: Channel control bit 7 is the channel flag. Each capture or match sets it, and it clears under the same read-then-write-zero rule as R6. `irq_ch[n]` is the flag ANDed with bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered one cycle after rd_en |
| ext_clk | input | 1 | External count clock, asynchronous |
| ch_in | input | 2 | Channel capture inputs, asynchronous |
| ch_out | output | 2 | Channel compare pins |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_ch | output | 2 | Channel interrupt requests |

## Verification
The assertions assume that reset is held at the start, so `$past` never looks at values from before the first edge. They also assume software never writes a reset bit during reset. The step check accepts either a +1 or a move to zero, because a MOD written below the current count lets the counter run on to 0xFFFF. The stimulus drives every register access and pin change half a cycle away from the clock edge. It holds each capture level for several clocks so the synchroniser always sees it. It writes MOD only while the counter is stopped or just cleared.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int ADDR_W   = 3;
  localparam int FLAG_BIT = 7;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MOD   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT   = 3'd2;
  localparam logic [ADDR_W-1:0] A_C0CTL = 3'd3;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_CAP = 2'b01,
    MODE_CMP = 2'b10,
    MODE_RSV = 2'b11
  } ch_mode_e;
endpackage

// File: rtl/cct_flag.sv
// Sticky event flag, cleared by read-while-set followed by a write of zero.
module cct_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wbit,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (set)                          flag <= 1'b1;
      else if (wr_hit && armed && !wbit) flag <= 1'b0;
      if (wr_hit)                       armed <= 1'b0;
      else if (rd_hit && flag)          armed <= 1'b1;
    end
  end
endmodule

// File: rtl/cct_prescaler.sv
// Count-enable source: power-of-two bus clock divider or synchronised external edges.
module cct_prescaler #(
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            run,
  input  logic [SELW-1:0] sel,
  input  logic            ext_clk,
  output logic            tick
);
  localparam int DIVW = (1 << SELW) - 2;
  localparam logic [SELW-1:0] SEL_EXT = '1;

  logic [DIVW-1:0] div;
  logic [DIVW-1:0] low_mask;
  logic [2:0]      ext_sy;
  logic            hit;

  always_ff @(posedge clk) begin
    if (rst || clr)  div <= '0;
    else if (run)    div <= div + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ext_sy <= '0;
    else     ext_sy <= {ext_sy[1:0], ext_clk};
  end

  always_comb begin
    low_mask = ~({DIVW{1'b1}} << sel);
    if (sel == SEL_EXT) hit = ext_sy[1] && !ext_sy[2];
    else                hit = &(div | ~low_mask);
  end

  assign tick = run && hit && !clr;
endmodule

// File: rtl/cct_channel.sv
// One capture/compare channel with optional buffered-duty PWM.
module cct_channel
  import cct_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wrap,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          cin,
  input  logic          ctl_wr,
  input  logic          ctl_rd,
  input  logic          val_wr,
  input  logic          pwm_on,
  input  logic [CW-1:0] wdata,
  output logic          cout,
  output logic [7:0]    ctl_q,
  output logic [CW-1:0] val_q,
  output logic          irq
);
  logic [6:0]    cfg;
  logic [CW-1:0] duty;
  logic [2:0]    sy;
  logic          flag, rise, fall, cap, match, is_cmp;

  assign is_cmp = (cfg[1:0] == MODE_CMP);
  assign rise   = sy[1] && !sy[2];
  assign fall   = !sy[1] && sy[2];
  assign cap    = (cfg[1:0] == MODE_CAP) && ((cfg[2] && rise) || (cfg[3] && fall));
  assign match  = is_cmp && tick && (cnt_nxt == (pwm_on ? duty : val_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      val_q <= '0;
      duty  <= '0;
      sy    <= '0;
      cout  <= 1'b0;
    end else begin
      sy <= {sy[1:0], cin};
      if (ctl_wr) cfg <= wdata[6:0];
      if (cap)         val_q <= cnt;
      else if (val_wr) val_q <= wdata;
      if (pwm_on && wrap) duty <= val_q;
      if (match) begin
        if (pwm_on) cout <= 1'b0;
        else begin
          case (cfg[3:2])
            2'b01:   cout <= ~cout;
            2'b10:   cout <= 1'b0;
            2'b11:   cout <= 1'b1;
            default: cout <= cout;
          endcase
        end
      end else if (wrap && is_cmp) begin
        if (pwm_on)      cout <= 1'b1;
        else if (cfg[4]) cout <= ~cout;
      end
    end
  end

  cct_flag u_flag (
    .clk   (clk),
    .rst   (rst),
    .set   (cap || match),
    .rd_hit(ctl_rd),
    .wr_hit(ctl_wr),
    .wbit  (wdata[FLAG_BIT]),
    .flag  (flag)
  );

  assign ctl_q = {flag, cfg};
  assign irq   = flag && cfg[5];
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cct_pkg::*;
#(
  parameter int CW   = 16,
  parameter int SELW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     rdata,
  input  logic              ext_clk,
  input  logic [1:0]        ch_in,
  output logic [1:0]        ch_out,
  output logic              irq_ovf,
  output logic [1:0]        irq_ch
);
  localparam int NCH    = 2;
  localparam int IE_BIT = SELW + 2;

  logic            stop_q, ovf_ie, ovf_flag;
  logic [SELW-1:0] sel_q;
  logic [CW-1:0]   mod_q, cnt, cnt_nxt, top_val;
  logic            tick, wrap, clr, wr_ctrl, pair;
  logic [7:0]      ctl_q [NCH];
  logic [CW-1:0]   val_q [NCH];

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign clr     = wr_ctrl && wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 1'b1;
      sel_q  <= '0;
      ovf_ie <= 1'b0;
      mod_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        stop_q <= wdata[0];
        sel_q  <= wdata[2 +: SELW];
        ovf_ie <= wdata[IE_BIT];
      end
      if (wr_en && addr == A_MOD) mod_q <= wdata;
    end
  end

  cct_prescaler #(.SELW(SELW)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .run    (!stop_q),
    .sel    (sel_q),
    .ext_clk(ext_clk),
    .tick   (tick)
  );

  assign top_val = (mod_q == '0) ? '1 : mod_q;
  assign wrap    = tick && (cnt == top_val);
  assign cnt_nxt = wrap ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= cnt_nxt;
  end

  cct_flag u_ovf_flag (
    .clk   (clk),
    .rst   (rst),
    .set   (wrap),
    .rd_hit(rd_en && addr == A_CTRL),
    .wr_hit(wr_ctrl),
    .wbit  (wdata[FLAG_BIT]),
    .flag  (ovf_flag)
  );
  assign irq_ovf = ovf_flag && ovf_ie;

  assign pair = ctl_q[0][6] && (ctl_q[0][1:0] == MODE_CMP);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(int'(A_C0CTL) + 2 * i);
    localparam logic [ADDR_W-1:0] VAL_A = ADDR_W'(int'(A_C0CTL) + 2 * i + 1);
    logic val_wr;
    if (i == 0) begin : g_lead
      assign val_wr = wr_en && (addr == VAL_A ||
                      (pair && addr == ADDR_W'(int'(A_C0CTL) + 3)));
    end else begin : g_follow
      assign val_wr = wr_en && addr == VAL_A && !pair;
    end
    cct_channel #(.CW(CW)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .wrap   (wrap),
      .cnt    (cnt),
      .cnt_nxt(cnt_nxt),
      .cin    (ch_in[i]),
      .ctl_wr (wr_en && addr == CTL_A),
      .ctl_rd (rd_en && addr == CTL_A),
      .val_wr (val_wr),
      .pwm_on ((i == 0) ? pair : 1'b0),
      .wdata  (wdata),
      .cout   (ch_out[i]),
      .ctl_q  (ctl_q[i]),
      .val_q  (val_q[i]),
      .irq    (irq_ch[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_CTRL:  rdata <= CW'({ovf_flag, 1'b0, ovf_ie, sel_q, 1'b0, stop_q});
        A_MOD:   rdata <= mod_q;
        A_CNT:   rdata <= cnt;
        3'd3:    rdata <= CW'(ctl_q[0]);
        3'd4:    rdata <= val_q[0];
        3'd5:    rdata <= CW'(ctl_q[1]);
        3'd6:    rdata <= val_q[1];
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          stop_q,
  input logic          clr,
  input logic          wrap,
  input logic [CW-1:0] cnt,
  input logic          ovf_flag,
  input logic [1:0]    ch_out
);
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr) && cnt != $past(cnt)) |-> (cnt == CW'($past(cnt) + 1'b1) || cnt == '0));

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(stop_q) && !$past(clr)) |-> cnt == $past(cnt));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> cnt == '0);

  // R6
  wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wrap) |-> ovf_flag);

  // R8
  pin_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_out != $past(ch_out)) |-> $past(tick));
endmodule

bind cc_timer cc_timer_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .stop_q  (stop_q),
  .clr     (clr),
  .wrap    (wrap),
  .cnt     (cnt),
  .ovf_flag(ovf_flag),
  .ch_out  (ch_out)
);

// File: tb/cc_timer_bench.sv
module cc_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ext_clk = 1'b0;
  logic [1:0]  ch_in = '0;
  logic [1:0]  ch_out, irq_ch;
  logic        irq_ovf;

  int n_chk = 0, n_fail = 0, cyc = 0, c0 = 0;
  bit done = 0;

  typedef struct { logic [15:0] v; string tag; } exp_t;
  exp_t sb_q[$];
  logic rd_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) rd_q <= rd_en;

  cc_timer u_cc_timer (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .ext_clk(ext_clk), .ch_in(ch_in),
    .ch_out(ch_out), .irq_ovf(irq_ovf), .irq_ch(irq_ch)
  );

  // monitor: pops the scoreboard as read data appears
  always @(negedge clk) begin
    if (rd_q) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (rdata !== e.v) begin
        n_fail++;
        $display("FAIL %s: rdata actual %h expected %h", e.tag, rdata, e.v);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic [15:0] v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    sb_q.push_back(e);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic run_from_zero();
    wr(3'd0, 16'h0000);
    c0 = cyc;
  endtask

  task automatic wait_j(input int j);
    while (cyc - c0 < j) @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R4 reset state
    rd_exp(3'd0, 16'h0001, "R4 ctrl reset");
    rd_exp(3'd2, 16'h0000, "R4 cnt reset");
    chk(ch_out[0] | ch_out[1] | irq_ovf | irq_ch[0] | irq_ch[1], 1'b0, "R4 outputs reset");

    // R1 modulo wrap, R2 reads during counting
    wr(3'd1, 16'd5);
    run_from_zero();
    rd_exp(3'd2, 16'd0, "R2 cnt read 0");
    rd_exp(3'd2, 16'd1, "R2 cnt read 1");
    repeat (6) @(negedge clk);
    wr(3'd0, 16'h0001);
    rd_exp(3'd2, 16'd3, "R1 R2 cnt after 9 ticks mod 5");

    // R6 flag and interrupt
    rd_exp(3'd0, 16'h0081, "R6 ovf flag set");
    wr(3'd0, 16'h00A1);
    chk(irq_ovf, 1'b1, "R6 irq_ovf enabled");
    wr(3'd0, 16'h0021);
    rd_exp(3'd0, 16'h00A1, "R6 no clear without read");
    wr(3'd0, 16'h0001);
    rd_exp(3'd0, 16'h0001, "R6 cleared after read");
    chk(irq_ovf, 1'b0, "R6 irq_ovf low");

    // R5 reset bit
    wr(3'd0, 16'h0003);
    rd_exp(3'd2, 16'd0, "R5 cnt cleared");
    rd_exp(3'd0, 16'h0001, "R5 reset bit reads 0");

    // R3 divide by 4, R4 stop holds
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h000B);
    wr(3'd0, 16'h0008);
    repeat (15) @(negedge clk);
    wr(3'd0, 16'h0009);
    rd_exp(3'd2, 16'd4, "R3 divide by 4");
    repeat (10) @(negedge clk);
    rd_exp(3'd2, 16'd4, "R4 stopped holds");

    // R3 external clock
    wr(3'd0, 16'h001F);
    wr(3'd0, 16'h001C);
    for (int k = 0; k < 3; k++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    wr(3'd0, 16'h001D);
    rd_exp(3'd2, 16'd3, "R3 external edges");

    // R8 set action
    wr(3'd0, 16'h0003);
    wr(3'd3, 16'h000E);
    wr(3'd4, 16'd3);
    run_from_zero();
    wait_j(2); chk(ch_out[0], 1'b0, "R8 set before match");
    wait_j(3); chk(ch_out[0], 1'b1, "R8 set at match");
    chk(irq_ch[0], 1'b0, "R11 irq masked");
    wr(3'd0, 16'h0001);
    rd_exp(3'd3, 16'h008E, "R11 channel flag set");

    // R8 clear action, R11 flag clear and irq
    wr(3'd0, 16'h0003);
    wr(3'd3, 16'h002A);
    wr(3'd4, 16'd2);
    rd_exp(3'd3, 16'h002A, "R11 flag cleared after read");
    run_from_zero();
    wait_j(1); chk(ch_out[0], 1'b1, "R8 clear before match");
    wait_j(2); chk(ch_out[0], 1'b0, "R8 clear at match");
    chk(irq_ch[0], 1'b1, "R11 irq on match");
    wr(3'd0, 16'h0001);

    // R8 toggle, R9 toggle on wrap
    wr(3'd0, 16'h0003);
    wr(3'd1, 16'd4);
    wr(3'd5, 16'h0016);
    wr(3'd6, 16'd2);
    run_from_zero();
    wait_j(1); chk(ch_out[1], 1'b0, "R8 toggle before match");
    wait_j(2); chk(ch_out[1], 1'b1, "R8 toggle at match");
    wait_j(5); chk(ch_out[1], 1'b0, "R9 toggle on wrap");
    wait_j(7); chk(ch_out[1], 1'b1, "R8 toggle second match");
    wr(3'd0, 16'h0001);

    // R7 capture
    wr(3'd0, 16'h0003);
    wr(3'd1, 16'd0);
    run_from_zero();
    repeat (4) @(negedge clk);
    wr(3'd0, 16'h0001);
    rd_exp(3'd5, 16'h0096, "R11 ch1 flag from matches");
    wr(3'd5, 16'h0009);
    ch_in[1] = 1'b1; repeat (5) @(negedge clk);
    rd_exp(3'd5, 16'h0009, "R7 rising ignored flag");
    rd_exp(3'd6, 16'd2, "R7 rising ignored value");
    ch_in[1] = 1'b0; repeat (5) @(negedge clk);
    rd_exp(3'd6, 16'd5, "R7 falling capture value");
    rd_exp(3'd5, 16'h0089, "R7 falling capture flag");
    rd_exp(3'd3, 16'h00AA, "R11 ch0 flag held");
    wr(3'd3, 16'h0005);
    ch_in[0] = 1'b1; repeat (5) @(negedge clk);
    rd_exp(3'd4, 16'd5, "R7 rising capture value");
    rd_exp(3'd3, 16'h0085, "R7 rising capture flag");

    // R10 buffered PWM
    wr(3'd0, 16'h0003);
    wr(3'd1, 16'd9);
    wr(3'd3, 16'h0042);
    wr(3'd6, 16'd4);
    run_from_zero();
    wait_j(20); chk(ch_out[0], 1'b1, "R10 high at wrap");
    wait_j(21); wr(3'd4, 16'd6);
    wait_j(23); chk(ch_out[0], 1'b1, "R10 high before duty");
    wait_j(24); chk(ch_out[0], 1'b0, "R10 old duty kept until wrap");
    wait_j(30); chk(ch_out[0], 1'b1, "R10 high at next wrap");
    wait_j(34); chk(ch_out[0], 1'b1, "R10 new duty after wrap");
    wait_j(36); chk(ch_out[0], 1'b0, "R10 low at new duty");
    wr(3'd0, 16'h0001);

    finish_run();
  end
endmodule